// File: doc/BRIEF.md
# Zero-Overhead Loop Sequencer

This block runs a counted loop for a processor with 16-bit instructions without spending any instruction on the loop branch. Software sets the loop's first address and last address, each relative to the PC of the instruction that sets it. It then loads a repeat count, either from an 8-bit immediate or from the low 12 bits of a general register. Each time the executing PC reaches the last instruction of the loop, the sequencer sends fetch back to the first instruction and decrements the count. On the last pass it lets execution fall through and the loop becomes inactive.

A loop is active while bit 0 of the stored end address is set. A count load sets that bit, and a count of zero leaves it clear. A 2-bit repetition class is kept in step with the counter. Mis-programming raises a one-cycle illegal-instruction pulse instead of changing state. This happens when a branch sits at the end of an active loop, when a count is loaded before both addresses have been set, and when a count load is placed directly before the loop's first instruction. All four state registers appear on save ports and can be written back in one cycle, so an exception handler can stash the loop and resume it later.

Top module: `hwloop_ctrl`

## Requirements
- R1: After reset the start register, end register, counter and class all read 0, and `loop_active`, `redirect_valid` and `illegal_exc` are 0.
- R2: `op_set_start` stores `pc + 2*disp` in the start register at the next clock edge, where `disp` is a signed two's-complement value.
- R3: `op_set_end` stores `pc + 2*disp` in the end register at the next clock edge, with bit 0 forced to 0. This deactivates any running loop.
- R4: `op_cnt_imm` loads the zero-extended `imm` into the 12-bit counter, and `op_cnt_reg` loads `reg_operand[11:0]`. A nonzero count sets end-register bit 0, so `loop_active` becomes 1. A count of 0 clears that bit.
- R5: The class field is 00 when the count is 0, 01 for 1, 10 for 2 and 11 for 3 or more. It follows the counter after loads and after each decrement.
- R6: A loop-end match is an active loop with `pc[31:1]` equal to end-register bits [31:1]. On a match with `is_branch` low and a count above 1, `redirect_valid` is 1 in the same cycle, `redirect_pc` equals the start register, and the counter drops by 1 at the next edge.
- R7: On a loop-end match with `is_branch` low and a count of 1, there is no redirect. At the next edge the counter and class become 0 and `loop_active` becomes 0.
- R8: On a loop-end match with `is_branch` high, `illegal_exc` is 1 in the same cycle and `redirect_valid` is 0. The counter and active state are unchanged.
- R9: A count load issued before both the start and end registers have been written since reset raises `illegal_exc` in that cycle, and the load is dropped.
- R10: A count load whose `pc + 2` equals the start register raises `illegal_exc` in that cycle, and the load is dropped.
- R11: `restore_en` writes all four save-port values in one cycle and overrides any operation in that cycle. It also counts as both addresses having been set, so a restored loop continues exactly as the saved one would have.
- R12: Away from a loop-end match, or with no loop active, `redirect_valid` stays 0 and the counter holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_set_start | input | 1 | Set-start operation strobe |
| op_set_end | input | 1 | Set-end operation strobe |
| op_cnt_imm | input | 1 | Load count from immediate |
| op_cnt_reg | input | 1 | Load count from register operand |
| disp | input | 8 | Signed halfword displacement for set-start and set-end |
| imm | input | 8 | Immediate count |
| reg_operand | input | 32 | Register operand; bits [11:0] are used |
| pc | input | 32 | PC of the instruction executing this cycle |
| is_branch | input | 1 | Instruction at `pc` is a branch |
| restore_en | input | 1 | Write all loop state from the restore ports |
| restore_start | input | 32 | Start value to restore |
| restore_end | input | 32 | End value to restore, bit 0 included |
| restore_cnt | input | 12 | Counter value to restore |
| restore_cls | input | 2 | Class value to restore |
| save_start | output | 32 | Current start register |
| save_end | output | 32 | Current end register, bit 0 = active |
| save_cnt | output | 12 | Current counter |
| save_cls | output | 2 | Current class field |
| loop_active | output | 1 | Loop is running |
| redirect_valid | output | 1 | Fetch must go to `redirect_pc` |
| redirect_pc | output | 32 | Redirect target |
| illegal_exc | output | 1 | Illegal-instruction pulse |

## Verification
The hardest situation to reach is a restore into the middle of a loop, followed by the loop finishing correctly. The saved state must come from a loop that has already passed its end at least once, and the registers must then be overwritten by unrelated programming before the restore. A directed sequence runs one pass of a three-pass loop, captures the save ports, reprograms the block, restores the captured values and walks the PC until the loop falls through. Random traffic then places the PC on the masked end address a quarter of the time, so branches at the loop end, last passes and restores with random counts keep occurring against the bench's reference model.

// File: rtl/hwloop_pkg.sv
// Package: shared class encoding for the loop sequencer.
// Assumes counts fit in 32 bits when passed to class_of.
package hwloop_pkg;

    localparam int CLS_W = 2;

    typedef enum logic [CLS_W-1:0] {
        CLS_NONE = 2'b00,
        CLS_ONE  = 2'b01,
        CLS_TWO  = 2'b10,
        CLS_MANY = 2'b11
    } rep_class_e;

    // Map a repeat count onto its repetition class.
    function automatic rep_class_e class_of(input int unsigned c);
        if (c == 0)      return CLS_NONE;
        else if (c == 1) return CLS_ONE;
        else if (c == 2) return CLS_TWO;
        else             return CLS_MANY;
    endfunction

endpackage

// File: rtl/hwloop_seq.sv
// Module: combinational loop-end detection and legality checks.
// Assumes op strobes are one-hot and pc is the executing instruction.
module hwloop_seq #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 12
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic              is_branch,
    input  logic [ADDR_W-1:0] start_q,
    input  logic [ADDR_W-1:0] end_q,
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic              ld_req,
    input  logic              both_set,
    output logic              redirect_valid,
    output logic [ADDR_W-1:0] redirect_pc,
    output logic              dec_en,
    output logic              finish_en,
    output logic              ld_ok,
    output logic              exc
);

    logic at_end;
    logic br_bad;
    logic ld_bad;
    logic more_passes;

    // Detect the loop-end instruction and decide redirect versus fall-through.
    always_comb begin
        at_end      = end_q[0] && (pc[ADDR_W-1:1] == end_q[ADDR_W-1:1]);
        more_passes = cnt_q > CNT_W'(1);
        br_bad      = at_end && is_branch;
        redirect_valid = at_end && !is_branch && more_passes;
        redirect_pc    = start_q;
        dec_en         = redirect_valid;
        finish_en      = at_end && !is_branch && !more_passes;
    end

    // Validate a count load against programming-order rules.
    always_comb begin
        ld_bad = ld_req && (!both_set || (start_q == pc + ADDR_W'(2)));
        ld_ok  = ld_req && !ld_bad;
        exc    = br_bad || ld_bad;
    end

endmodule

// File: rtl/hwloop_addr_regs.sv
// Module: loop start and end registers plus programming-order flags.
// End register bit 0 is the active flag; priority restore > set ops > active updates.
module hwloop_addr_regs #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restore_en,
    input  logic [ADDR_W-1:0] restore_start,
    input  logic [ADDR_W-1:0] restore_end,
    input  logic              set_start,
    input  logic              set_end,
    input  logic [ADDR_W-1:0] target,
    input  logic              act_set,
    input  logic              act_clr,
    output logic [ADDR_W-1:0] start_q,
    output logic [ADDR_W-1:0] end_q,
    output logic              both_set
);

    logic start_seen;
    logic end_seen;

    // Hold the start address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q    <= '0;
            start_seen <= 1'b0;
        end else if (restore_en) begin
            start_q    <= restore_start;
            start_seen <= 1'b1;
        end else if (set_start) begin
            start_q    <= target;
            start_seen <= 1'b1;
        end
    end

    // Hold the end address and its active bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            end_q    <= '0;
            end_seen <= 1'b0;
        end else if (restore_en) begin
            end_q    <= restore_end;
            end_seen <= 1'b1;
        end else if (set_end) begin
            end_q    <= {target[ADDR_W-1:1], 1'b0};
            end_seen <= 1'b1;
        end else if (act_set) begin
            end_q[0] <= 1'b1;
        end else if (act_clr) begin
            end_q[0] <= 1'b0;
        end
    end

    assign both_set = start_seen && end_seen;

endmodule

// File: rtl/hwloop_counter.sv
// Module: repeat counter with its repetition class.
// Priority restore > load > decrement > finish.
module hwloop_counter
    import hwloop_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restore_en,
    input  logic [CNT_W-1:0] restore_cnt,
    input  logic [CLS_W-1:0] restore_cls,
    input  logic             ld_en,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             dec_en,
    input  logic             finish_en,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CLS_W-1:0] cls_q
);

    logic [CNT_W-1:0] cnt_dec;
    assign cnt_dec = cnt_q - CNT_W'(1);

    // Update the count and keep the class in step with it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cls_q <= CLS_NONE;
        end else if (restore_en) begin
            cnt_q <= restore_cnt;
            cls_q <= restore_cls;
        end else if (ld_en) begin
            cnt_q <= ld_val;
            cls_q <= class_of(int'(ld_val));
        end else if (dec_en) begin
            cnt_q <= cnt_dec;
            cls_q <= class_of(int'(cnt_dec));
        end else if (finish_en) begin
            cnt_q <= '0;
            cls_q <= CLS_NONE;
        end
    end

endmodule

// File: rtl/hwloop_ctrl.sv
// Module: top of the zero-overhead loop sequencer.
// Assumes one-hot op strobes and one instruction per cycle at pc.
module hwloop_ctrl
    import hwloop_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 12,
    parameter int IMM_W  = 8,
    parameter int DISP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_set_start,
    input  logic              op_set_end,
    input  logic              op_cnt_imm,
    input  logic              op_cnt_reg,
    input  logic [DISP_W-1:0] disp,
    input  logic [IMM_W-1:0]  imm,
    input  logic [DATA_W-1:0] reg_operand,
    input  logic [ADDR_W-1:0] pc,
    input  logic              is_branch,
    input  logic              restore_en,
    input  logic [ADDR_W-1:0] restore_start,
    input  logic [ADDR_W-1:0] restore_end,
    input  logic [CNT_W-1:0]  restore_cnt,
    input  logic [CLS_W-1:0]  restore_cls,
    output logic [ADDR_W-1:0] save_start,
    output logic [ADDR_W-1:0] save_end,
    output logic [CNT_W-1:0]  save_cnt,
    output logic [CLS_W-1:0]  save_cls,
    output logic              loop_active,
    output logic              redirect_valid,
    output logic [ADDR_W-1:0] redirect_pc,
    output logic              illegal_exc
);

    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] target;
    logic [CNT_W-1:0]  ld_val;
    logic              ld_req;
    logic              ld_ok;
    logic              dec_en;
    logic              finish_en;
    logic              both_set;
    logic              act_set;
    logic              act_clr;
    logic              unused_hi;

    // Form the PC-relative target and select the count source.
    always_comb begin
        disp_ext = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
        target   = pc + {disp_ext[ADDR_W-2:0], 1'b0};
        ld_req   = op_cnt_imm || op_cnt_reg;
        ld_val   = op_cnt_imm ? CNT_W'(imm) : reg_operand[CNT_W-1:0];
        act_set  = ld_ok && (ld_val != '0);
        act_clr  = (ld_ok && (ld_val == '0)) || finish_en;
    end

    assign unused_hi = ^reg_operand[DATA_W-1:CNT_W];

    hwloop_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .pc             (pc),
        .is_branch      (is_branch),
        .start_q        (save_start),
        .end_q          (save_end),
        .cnt_q          (save_cnt),
        .ld_req         (ld_req),
        .both_set       (both_set),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .dec_en         (dec_en),
        .finish_en      (finish_en),
        .ld_ok          (ld_ok),
        .exc            (illegal_exc)
    );

    hwloop_addr_regs #(.ADDR_W(ADDR_W)) u_addr (
        .clk           (clk),
        .rst_n         (rst_n),
        .restore_en    (restore_en),
        .restore_start (restore_start),
        .restore_end   (restore_end),
        .set_start     (op_set_start),
        .set_end       (op_set_end),
        .target        (target),
        .act_set       (act_set),
        .act_clr       (act_clr),
        .start_q       (save_start),
        .end_q         (save_end),
        .both_set      (both_set)
    );

    hwloop_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .restore_en  (restore_en),
        .restore_cnt (restore_cnt),
        .restore_cls (restore_cls),
        .ld_en       (ld_ok),
        .ld_val      (ld_val),
        .dec_en      (dec_en),
        .finish_en   (finish_en),
        .cnt_q       (save_cnt),
        .cls_q       (save_cls)
    );

    assign loop_active = save_end[0];

endmodule

// File: rtl/hwloop_ctrl_chk.sv
// Checker: temporal properties of the loop sequencer, bound to the top.
// Assumes restored class values agree with restored counts.
module hwloop_ctrl_chk
    import hwloop_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 12,
    parameter int IMM_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_set_start,
    input logic              op_set_end,
    input logic              op_cnt_imm,
    input logic              op_cnt_reg,
    input logic [IMM_W-1:0]  imm,
    input logic [ADDR_W-1:0] pc,
    input logic              is_branch,
    input logic              restore_en,
    input logic [ADDR_W-1:0] save_start,
    input logic [ADDR_W-1:0] save_end,
    input logic [CNT_W-1:0]  save_cnt,
    input logic [CLS_W-1:0]  save_cls,
    input logic              loop_active,
    input logic              redirect_valid,
    input logic [ADDR_W-1:0] redirect_pc,
    input logic              illegal_exc
);

    logic any_op;
    logic at_end;
    assign any_op = op_set_start || op_set_end || op_cnt_imm || op_cnt_reg || restore_en;
    assign at_end = loop_active && (pc[ADDR_W-1:1] == save_end[ADDR_W-1:1]);

    p_cls_tracks_cnt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        save_cls == class_of(int'(save_cnt)));

    p_redirect_needs_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (loop_active && save_cnt > CNT_W'(1) && redirect_pc == save_start));

    p_redirect_decrements_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid && !any_op) |=> (save_cnt == $past(save_cnt) - CNT_W'(1)));

    p_last_pass_exits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (at_end && !is_branch && save_cnt == CNT_W'(1) && !any_op) |=> (!loop_active && save_cnt == '0));

    p_branch_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (at_end && is_branch) |-> (illegal_exc && !redirect_valid));

    p_imm_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_cnt_imm && !illegal_exc && !restore_en && imm != '0) |=> (loop_active && save_cnt == CNT_W'($past(imm))));

    p_idle_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!at_end && !any_op) |=> $stable(save_cnt));

endmodule

bind hwloop_ctrl hwloop_ctrl_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .IMM_W(IMM_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .op_set_start   (op_set_start),
    .op_set_end     (op_set_end),
    .op_cnt_imm     (op_cnt_imm),
    .op_cnt_reg     (op_cnt_reg),
    .imm            (imm),
    .pc             (pc),
    .is_branch      (is_branch),
    .restore_en     (restore_en),
    .save_start     (save_start),
    .save_end       (save_end),
    .save_cnt       (save_cnt),
    .save_cls       (save_cls),
    .loop_active    (loop_active),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .illegal_exc    (illegal_exc)
);

// File: tb/hwloop_ctrl_tb.sv
module hwloop_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_set_start = 0, op_set_end = 0, op_cnt_imm = 0, op_cnt_reg = 0;
    logic [7:0]  disp = 0, imm = 0;
    logic [31:0] reg_operand = 0, pc = 0;
    logic        is_branch = 0, restore_en = 0;
    logic [31:0] restore_start = 0, restore_end = 0;
    logic [11:0] restore_cnt = 0;
    logic [1:0]  restore_cls = 0;
    logic [31:0] save_start, save_end, redirect_pc;
    logic [11:0] save_cnt;
    logic [1:0]  save_cls;
    logic        loop_active, redirect_valid, illegal_exc;

    int total = 0;
    int bad = 0;

    // reference model state
    logic [31:0] m_start = 0, m_end = 0;
    logic [11:0] m_cnt = 0;
    logic [1:0]  m_cls = 0;
    logic        m_ss = 0, m_es = 0, m_last_red = 0, m_last_exc = 0;

    always #4 clk = ~clk;

    hwloop_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .op_set_start(op_set_start), .op_set_end(op_set_end),
        .op_cnt_imm(op_cnt_imm), .op_cnt_reg(op_cnt_reg),
        .disp(disp), .imm(imm), .reg_operand(reg_operand), .pc(pc),
        .is_branch(is_branch), .restore_en(restore_en),
        .restore_start(restore_start), .restore_end(restore_end),
        .restore_cnt(restore_cnt), .restore_cls(restore_cls),
        .save_start(save_start), .save_end(save_end),
        .save_cnt(save_cnt), .save_cls(save_cls),
        .loop_active(loop_active), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .illegal_exc(illegal_exc)
    );

    function automatic logic [1:0] cls_ref(input logic [11:0] c);
        return (c >= 12'd3) ? 2'b11 : c[1:0];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle();
        op_set_start = 0; op_set_end = 0; op_cnt_imm = 0; op_cnt_reg = 0;
        is_branch = 0; restore_en = 0;
    endtask

    // Inputs are driven after a falling edge; check outputs, advance model, check state.
    task automatic step();
        logic at_end, e_br, e_red, ld, e_ldbad, e_exc;
        logic [31:0] tgt;
        logic [11:0] c;
        #1;
        at_end  = m_end[0] && (pc[31:1] == m_end[31:1]);
        e_br    = at_end && is_branch;
        e_red   = at_end && !is_branch && (m_cnt > 12'd1);
        ld      = op_cnt_imm || op_cnt_reg;
        e_ldbad = ld && (!(m_ss && m_es) || (m_start == pc + 32'd2));
        e_exc   = e_br || e_ldbad;
        chk(at_end ? "R6" : "R12", {31'b0, redirect_valid}, {31'b0, e_red});
        if (e_red) chk("R6", redirect_pc, m_start);
        chk(e_br ? "R8" : (ld && !(m_ss && m_es)) ? "R9" : ld ? "R10" : "R12",
            {31'b0, illegal_exc}, {31'b0, e_exc});
        m_last_red = e_red;
        m_last_exc = e_exc;
        if (restore_en) begin
            m_start = restore_start; m_end = restore_end;
            m_cnt = restore_cnt; m_cls = restore_cls; m_ss = 1; m_es = 1;
        end else begin
            if (e_red) begin
                m_cnt = m_cnt - 12'd1; m_cls = cls_ref(m_cnt);
            end else if (at_end && !is_branch) begin
                m_cnt = 0; m_cls = 0; m_end[0] = 1'b0;
            end
            tgt = pc + {{23{disp[7]}}, disp, 1'b0};
            if (op_set_start) begin m_start = tgt; m_ss = 1; end
            if (op_set_end) begin m_end = {tgt[31:1], 1'b0}; m_es = 1; end
            if (ld && !e_ldbad) begin
                c = op_cnt_imm ? {4'b0, imm} : reg_operand[11:0];
                m_cnt = c; m_cls = cls_ref(c); m_end[0] = (c != 0);
            end
        end
        @(negedge clk);
        chk("R2", save_start, m_start);
        chk("R3", save_end, m_end);
        chk("R4", {20'b0, save_cnt}, {20'b0, m_cnt});
        chk("R5", {30'b0, save_cls}, {30'b0, m_cls});
        chk("R7", {31'b0, loop_active}, {31'b0, m_end[0]});
        idle();
    endtask

    task automatic do_op(input int kind, input logic [31:0] p, input logic [7:0] d, input logic [31:0] v);
        pc = p; disp = d;
        case (kind)
            0: op_set_start = 1;
            1: op_set_end = 1;
            2: begin op_cnt_imm = 1; imm = v[7:0]; end
            3: begin op_cnt_reg = 1; reg_operand = v; end
            default: ;
        endcase
        step();
    endtask

    // Walk pc through the loop until it falls past the end address.
    task automatic run_loop(input logic [31:0] from, input logic [31:0] last);
        pc = from;
        for (int g = 0; g < 400; g++) begin
            step();
            if (m_last_red) pc = m_start;
            else if (pc[31:1] == last[31:1]) begin pc = pc + 2; step(); break; end
            else pc = pc + 2;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [31:0] s_start, s_end;
        logic [11:0] s_cnt;
        logic [1:0]  s_cls;
        int passes;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R1", {save_start, save_end}, 64'h0);
        chk("R1", {20'b0, save_cnt, save_cls, loop_active, redirect_valid, illegal_exc}, 0);

        // R9: count before addresses set
        do_op(2, 32'h100, 8'd0, 32'd5);
        chk("R9", {31'b0, m_last_exc}, 1);
        chk("R9", {20'b0, save_cnt}, 0);

        // R2/R3/R4: program a three-pass loop, negative and positive displacements
        do_op(0, 32'h110, 8'hFC, 0);          // start = 0x110 - 8 = 0x108
        chk("R2", save_start, 32'h108);
        do_op(1, 32'h102, 8'd8, 0);           // end = 0x112
        chk("R3", save_end, 32'h112);
        do_op(2, 32'h104, 8'd0, 32'd3);
        chk("R4", {31'b0, loop_active}, 1);
        chk("R5", {30'b0, save_cls}, 2'b11);
        pc = 32'h106; step();
        run_loop(32'h108, 32'h112);
        chk("R7", {31'b0, loop_active}, 0);

        // R10: start equals pc+2 of the count load
        do_op(0, 32'h200, 8'd1, 0);           // start = 0x202
        do_op(1, 32'h200, 8'd8, 0);
        do_op(2, 32'h200, 8'd0, 32'd4);
        chk("R10", {31'b0, m_last_exc}, 1);
        chk("R10", {31'b0, loop_active}, 0);

        // R4: register count uses low 12 bits; zero count stays inactive
        do_op(3, 32'h1F0, 8'd0, 32'h0001_0ABC);
        chk("R4", {20'b0, save_cnt}, 32'hABC);
        do_op(3, 32'h1F0, 8'd0, 32'h0000_1000);
        chk("R4", {31'b0, loop_active}, 0);

        // R8: branch at loop end
        do_op(2, 32'h1F0, 8'd0, 32'd2);
        pc = 32'h210; is_branch = 1; step();
        chk("R8", {31'b0, m_last_exc}, 1);
        chk("R8", {20'b0, save_cnt}, 2);
        run_loop(32'h202, 32'h210);

        // R11: save mid-loop, clobber, restore, resume
        do_op(0, 32'h300, 8'd4, 0);           // 0x308
        do_op(1, 32'h300, 8'd10, 0);          // 0x314
        do_op(2, 32'h302, 8'd0, 32'd3);
        pc = 32'h314; step();
        s_start = save_start; s_end = save_end; s_cnt = save_cnt; s_cls = save_cls;
        do_op(1, 32'h400, 8'd2, 0);
        do_op(2, 32'h400, 8'd0, 32'd9);
        restore_en = 1; restore_start = s_start; restore_end = s_end;
        restore_cnt = s_cnt; restore_cls = s_cls; op_set_start = 1; pc = 32'h500;
        step();
        chk("R11", save_end, 32'h315);
        chk("R11", {20'b0, save_cnt}, 2);
        passes = 0;
        pc = 32'h308;
        for (int g = 0; g < 40; g++) begin
            step();
            if (m_last_red) begin passes++; pc = m_start; end
            else if (pc == 32'h314) break;
            else pc = pc + 2;
        end
        chk("R11", passes, 1);
        chk("R11", {31'b0, loop_active}, 0);

        // constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom % 12;
            pc = (($urandom % 4) == 0 && m_end[0]) ? {m_end[31:1], 1'b0}
                                                   : 32'h100 + 2 * ($urandom % 32);
            disp = $urandom % 256;
            is_branch = ($urandom % 6) == 0;
            imm = (($urandom % 10) == 0) ? 8'd255 : 8'($urandom % 6);
            reg_operand = (($urandom % 2) == 0) ? $urandom : ($urandom % 5);
            case (r)
                0: op_set_start = 1;
                1: op_set_end = 1;
                2: op_cnt_imm = 1;
                3: op_cnt_reg = 1;
                default: ;
            endcase
            if (($urandom % 40) == 0) begin
                restore_en = 1;
                restore_cnt = 12'($urandom % 6);
                restore_cls = cls_ref(restore_cnt);
                restore_start = 32'h100 + 2 * ($urandom % 32);
                restore_end = (32'h100 + 2 * ($urandom % 32)) | {31'b0, restore_cnt != 0};
            end
            step();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule